// File: doc/BRIEF.md
# Serial ADC Command and Result Interface

This block is the digital front end of a multichannel serial analog-to-digital converter. A host drives chip-select low and clocks command bits in on a serial data input. The falling edge of chip-select does nothing by itself: the block waits for the first logic 1 on the data input and treats that bit as the first bit of an 8-bit command. The command picks an input channel, unipolar or bipolar coding, single-ended or differential input, and a clock/power code. On the serial-clock falling edge that follows the last command bit, a conversion starts. The 12-bit result then leaves MSB first on the serial data output.

A parallel sample port stands in for the analog core, and its value is taken as the conversion result. There are two clock modes. In external mode the host's serial clock carries the conversion, and the sample is taken at the starting edge. In internal mode a strobe output goes low for a parameterized number of system clocks, and the result is ready when the strobe returns high. A three-state shutdown input sets the internal-conversion length (slow or fast) or forces a full power-down. All serial pins are synchronised to the system clock, and serial-clock edges are found by comparing successive synchronised samples.

Top module: `sadc_slave`

## Requirements
- R1: After reset the strobe is high, the clock mode is internal (ext_clk_mode = 0), power_down is 0, the decoded fields are 0, and DOUT stays 0 until a conversion has loaded a result.
- R2: Lowering chip-select starts nothing. While no command is in progress, zeros on DIN are ignored, and the first 1 sampled on a rising SCLK edge with chip-select low becomes the first command bit.
- R3: Command bits arrive MSB first: start (1), channel select bits 2, 1 and 0, unipolar flag (1 = unipolar), single-ended flag (1 = single-ended), then the two-bit code PD1 and PD0. The decoded outputs update when the eighth bit is sampled and hold otherwise.
- R4: Code 11 selects external mode and code 10 selects internal mode. Code 01 leaves the mode unchanged. Code 00 leaves the mode unchanged and sets power_down. Codes 01 and 00 still perform a conversion, and any later command with another code clears power_down.
- R5: In external mode the sample is captured on the SCLK falling edge after the eighth command bit, and B11 appears on DOUT at that edge. Each following falling edge presents the next lower bit down to B0, and after B0 DOUT stays 0.
- R6: In internal mode the strobe goes low on that falling edge. It stays low for CONV_CYC system clocks when shutdown is open, or CONV_CYC*SLOW_MUL system clocks when shutdown is high. It then rises with the sample captured and B11 on DOUT, and later falling edges shift out the lower bits.
- R7: While a result is being shifted out, a 1 on DIN is taken as a new start bit only once bit B5 is on DOUT. A 1 sampled while B6 or a higher bit is showing is ignored.
- R8: Chip-select high aborts everything in progress. The strobe returns high, DOUT drops to 0 and a partly received command is discarded. After chip-select falls again the next 1 on DIN starts a fresh command.
- R9: Shutdown low (code 00 on shdn_mode) forces power-down: power_down reads 1, DIN is ignored, the decoded fields keep their values and no conversion happens. shdn_mode 01 means shutdown high (slow internal clock), and 10 or 11 means open (fast).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command input, sampled on rising SCLK |
| shdn_mode | input | 2 | Shutdown pin state: 00 low, 01 high, 1x open |
| sample_in | input | RES_W | Parallel sample value standing in for the analog core |
| dout | output | 1 | Serial result output, changes on falling SCLK |
| sstrb | output | 1 | Conversion strobe, low during an internal conversion |
| chan_sel | output | 3 | Decoded channel select |
| unipolar | output | 1 | Decoded unipolar flag |
| single_ended | output | 1 | Decoded single-ended flag |
| ext_clk_mode | output | 1 | 1 when external clock mode is active |
| power_down | output | 1 | Software or hardware power-down active |

## Verification
An SCLK, chip-select or DIN change reaches the block's registers three system clocks later: two synchroniser stages, then the edge compare. So a sampled DIN bit or a DOUT update is in place about three cycles after the SCLK edge that causes it. The bench holds every SCLK level for eight system clocks and reads DOUT at the very end of each low half, well after the previous falling edge has taken effect. The internal-conversion strobe is measured in whole system clocks from its fall to its rise, and a tolerance of one cycle covers where the measurement starts. Chip-select and shutdown effects are sampled six cycles after the change.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int CMD_W = 8;               // start bit plus seven payload bits
    localparam int PAY_W = CMD_W - 1;

    typedef enum logic [1:0] {
        PD_OFF = 2'b00,
        PD_RSV = 2'b01,
        PD_INT = 2'b10,
        PD_EXT = 2'b11
    } pd_code_e;

    // Payload as it arrives after the start bit, first bit in the MSB.
    typedef struct packed {
        logic [2:0] sel;
        logic       unipolar;
        logic       single;
        pd_code_e   pd;
    } payload_t;

    function automatic logic shdn_forces_off(input logic [1:0] mode);
        return mode == 2'b00;
    endfunction

    function automatic logic shdn_is_slow(input logic [1:0] mode);
        return mode == 2'b01;
    endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int         W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
    import sadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             rise,
    input  logic             din,
    input  logic             allow,
    output logic             done,
    output logic [PAY_W-1:0] payload
);
    localparam int BC_W = $clog2(CMD_W);

    logic             busy;
    logic [BC_W-1:0]  cnt;
    logic [PAY_W-2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            sh      <= '0;
            done    <= 1'b0;
            payload <= '0;
        end else if (clear) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (rise) begin
                if (busy) begin
                    sh <= {sh[PAY_W-3:0], din};
                    if (cnt == BC_W'(CMD_W - 1)) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        payload <= {sh, din};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (allow && din) begin
                    busy <= 1'b1;
                    cnt  <= BC_W'(1);
                    sh   <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int CONV_CYC = 24,
    parameter int SLOW_MUL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             fall,
    input  logic             req,
    input  pd_code_e         pd,
    input  logic             slow,
    input  logic [RES_W-1:0] sample,
    output logic             dout,
    output logic             sstrb,
    output logic             allow,
    output logic             ext_mode,
    output logic             sw_pd
);
    localparam int SLOW_CYC   = CONV_CYC * SLOW_MUL;
    localparam int CC_W       = $clog2(SLOW_CYC + 1);
    localparam int SH_W       = $clog2(RES_W + 1);
    localparam int RESTART_AT = RES_W - 5;   // bits shown once B5 is out

    logic             pend;
    logic             conv;
    logic [CC_W-1:0]  cnt;
    logic [RES_W-1:0] sh;
    logic [SH_W-1:0]  shown;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            conv     <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
            shown    <= '0;
            sstrb    <= 1'b1;
            ext_mode <= 1'b0;
            sw_pd    <= 1'b0;
        end else if (abort) begin
            pend  <= 1'b0;
            conv  <= 1'b0;
            cnt   <= '0;
            sh    <= '0;
            shown <= '0;
            sstrb <= 1'b1;
        end else begin
            if (req) begin
                pend  <= 1'b1;
                sw_pd <= (pd == PD_OFF);
                if (pd == PD_EXT)      ext_mode <= 1'b1;
                else if (pd == PD_INT) ext_mode <= 1'b0;
            end
            if (conv) begin
                if (cnt == '0) begin
                    conv  <= 1'b0;
                    sstrb <= 1'b1;
                    sh    <= sample;
                    shown <= SH_W'(1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (fall) begin
                if (pend) begin
                    pend <= 1'b0;
                    if (ext_mode) begin
                        sh    <= sample;
                        shown <= SH_W'(1);
                    end else begin
                        conv  <= 1'b1;
                        sstrb <= 1'b0;
                        cnt   <= slow ? CC_W'(SLOW_CYC - 1) : CC_W'(CONV_CYC - 1);
                        sh    <= '0;
                        shown <= '0;
                    end
                end else begin
                    sh <= sh << 1;
                    if (shown != '0 && shown < SH_W'(RES_W))
                        shown <= shown + 1'b1;
                end
            end
        end
    end

    assign dout  = sh[RES_W-1];
    assign allow = !pend && !conv && (shown == '0 || shown >= SH_W'(RESTART_AT));
endmodule

// File: rtl/sadc_slave.sv
module sadc_slave
    import sadc_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int CONV_CYC = 24,
    parameter int SLOW_MUL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [1:0]       shdn_mode,
    input  logic [RES_W-1:0] sample_in,
    output logic             dout,
    output logic             sstrb,
    output logic [2:0]       chan_sel,
    output logic             unipolar,
    output logic             single_ended,
    output logic             ext_clk_mode,
    output logic             power_down
);
    logic [2:0] sync_q;
    logic       cs_q, sclk_q, din_q, sclk_prev;
    logic       sclk_rise, sclk_fall, hw_pd, abort;
    logic       allow, byte_done, sw_pd;
    logic [PAY_W-1:0] pay_raw;
    payload_t   pay;

    sadc_sync #(.W(3), .INIT(3'b001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({din, sclk, cs_n}),
        .q   (sync_q)
    );

    assign cs_q   = sync_q[0];
    assign sclk_q = sync_q[1];
    assign din_q  = sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_q;
    end

    assign sclk_rise = sclk_q && !sclk_prev && !cs_q;
    assign sclk_fall = !sclk_q && sclk_prev && !cs_q;
    assign hw_pd     = shdn_forces_off(shdn_mode);
    assign abort     = cs_q || hw_pd;

    sadc_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .clear   (abort),
        .rise    (sclk_rise),
        .din     (din_q),
        .allow   (allow),
        .done    (byte_done),
        .payload (pay_raw)
    );

    assign pay = payload_t'(pay_raw);

    sadc_seq #(.RES_W(RES_W), .CONV_CYC(CONV_CYC), .SLOW_MUL(SLOW_MUL)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .abort    (abort),
        .fall     (sclk_fall),
        .req      (byte_done),
        .pd       (pay.pd),
        .slow     (shdn_is_slow(shdn_mode)),
        .sample   (sample_in),
        .dout     (dout),
        .sstrb    (sstrb),
        .allow    (allow),
        .ext_mode (ext_clk_mode),
        .sw_pd    (sw_pd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_sel     <= '0;
            unipolar     <= 1'b0;
            single_ended <= 1'b0;
        end else if (byte_done) begin
            chan_sel     <= pay.sel;
            unipolar     <= pay.unipolar;
            single_ended <= pay.single;
        end
    end

    assign power_down = hw_pd || sw_pd;
endmodule

// File: rtl/sadc_slave_chk.sv
module sadc_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_q,
    input logic       hw_pd,
    input logic       sclk_fall,
    input logic       byte_done,
    input logic [1:0] pd_code,
    input logic       sstrb,
    input logic       dout,
    input logic       ext_clk_mode,
    input logic [2:0] chan_sel
);
    // R8
    cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
        cs_q |=> (sstrb && !dout));

    // R9
    hw_off_chk: assert property (@(posedge clk) disable iff (rst)
        hw_pd |=> (sstrb && !dout));

    // R6
    strobe_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !sstrb |-> !ext_clk_mode);

    // R6
    strobe_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sstrb) |-> $past(sclk_fall));

    // R4
    rsv_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && pd_code == 2'b01) |=> $stable(ext_clk_mode));

    // R3
    field_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_done |=> $stable(chan_sel));
endmodule

bind sadc_slave sadc_slave_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .cs_q         (cs_q),
    .hw_pd        (hw_pd),
    .sclk_fall    (sclk_fall),
    .byte_done    (byte_done),
    .pd_code      (pay.pd),
    .sstrb        (sstrb),
    .dout         (dout),
    .ext_clk_mode (ext_clk_mode),
    .chan_sel     (chan_sel)
);

// File: tb/sadc_slave_tb.sv
module sadc_slave_tb_top;
    localparam int RES_W    = 12;
    localparam int CONV_CYC = 24;
    localparam int SLOW_MUL = 4;
    localparam int HP       = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic [1:0] shdn_mode = 2'b10;
    logic [RES_W-1:0] sample_in = '0;
    logic dout, sstrb, unipolar, single_ended, ext_clk_mode, power_down;
    logic [2:0] chan_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sadc_slave #(.RES_W(RES_W), .CONV_CYC(CONV_CYC), .SLOW_MUL(SLOW_MUL)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .shdn_mode(shdn_mode), .sample_in(sample_in), .dout(dout), .sstrb(sstrb),
        .chan_sel(chan_sel), .unipolar(unipolar), .single_ended(single_ended),
        .ext_clk_mode(ext_clk_mode), .power_down(power_down)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cmd(input logic [2:0] sel, input logic uni,
                                       input logic sgl, input logic [1:0] pd);
        return {1'b1, sel, uni, sgl, pd};
    endfunction

    task automatic bitclk(input logic d, output logic o);
        @(negedge clk);
        din = d;
        repeat (HP) @(negedge clk);
        o = dout;
        sclk = 1'b1;
        repeat (HP) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] b);
        logic o;
        for (int i = 7; i >= 0; i--) bitclk(b[i], o);
    endtask

    task automatic read_res(output logic [RES_W-1:0] r);
        logic o;
        for (int i = RES_W - 1; i >= 0; i--) begin
            bitclk(1'b0, o);
            r[i] = o;
        end
    endtask

    task automatic wait_int(input int exp_len, input string req);
        int len = 0;
        int guard = 0;
        while (sstrb && guard < 10) begin @(negedge clk); guard++; end
        chk(req, int'(sstrb), 0);
        while (!sstrb && len < 5000) begin @(negedge clk); len++; end
        n_chk++;
        if (len < exp_len - 1 || len > exp_len + 1) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d strobe-low cycles", req, len, exp_len);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [RES_W-1:0] r, smp;
        logic [7:0] cb;
        logic o;
        logic [2:0] sel;
        logic uni, sgl, use_int;
        int lead;
        void'($urandom(32'h5AD1));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 sstrb", int'(sstrb), 1);
        chk("R1 dout", int'(dout), 0);
        chk("R1 mode", int'(ext_clk_mode), 0);
        chk("R1 power_down", int'(power_down), 0);
        chk("R1 fields", int'({chan_sel, unipolar, single_ended}), 0);

        // R2 chip-select fall and leading zeros start nothing
        cs_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            bitclk(1'b0, o);
            chk("R1 dout zero before conversion", int'(o), 0);
        end
        chk("R2 fields unchanged", int'(chan_sel), 0);

        // R3 R4 R5 external conversion
        sample_in = 12'hA5C;
        send_cmd(cmd(3'd5, 1'b1, 1'b0, 2'b11));
        chk("R3 chan_sel", int'(chan_sel), 5);
        chk("R3 unipolar", int'(unipolar), 1);
        chk("R3 single_ended", int'(single_ended), 0);
        chk("R4 ext mode", int'(ext_clk_mode), 1);
        read_res(r);
        chk("R5 result", int'(r), 'hA5C);
        bitclk(1'b0, o);
        chk("R5 zero fill", int'(o), 0);
        bitclk(1'b0, o);
        chk("R5 zero fill", int'(o), 0);

        // R7 start bit ignored while B6 shows, accepted once B5 shows
        sample_in = 12'h3C6;
        send_cmd(cmd(3'd2, 1'b0, 1'b0, 2'b11));
        cb = cmd(3'd6, 1'b0, 1'b1, 2'b11);
        r = '0;
        for (int i = 0; i < 14; i++) begin
            logic d;
            if (i == 1) sample_in = 12'h7E1;
            if (i < 5)       d = 1'b0;
            else if (i == 5) d = 1'b1;
            else             d = cb[13 - i];
            bitclk(d, o);
            if (i < 12) r[11 - i] = o;
            else chk("R5 zero fill after B0", int'(o), 0);
        end
        chk("R7 first result", int'(r), 'h3C6);
        chk("R7 chan_sel of early start", int'(chan_sel), 6);
        chk("R7 single_ended", int'(single_ended), 1);
        read_res(r);
        chk("R7 second result", int'(r), 'h7E1);

        // R4 unassigned code keeps mode and converts
        sample_in = 12'h0F3;
        send_cmd(cmd(3'd3, 1'b0, 1'b0, 2'b01));
        chk("R4 rsv mode kept", int'(ext_clk_mode), 1);
        chk("R4 rsv no power_down", int'(power_down), 0);
        read_res(r);
        chk("R4 rsv result", int'(r), 'h0F3);

        // R6 internal mode, fast
        shdn_mode = 2'b10;
        sample_in = 12'h951;
        send_cmd(cmd(3'd1, 1'b0, 1'b1, 2'b10));
        chk("R4 int mode", int'(ext_clk_mode), 0);
        wait_int(CONV_CYC, "R6 fast");
        read_res(r);
        chk("R6 fast result", int'(r), 'h951);

        // R6 internal mode, slow
        shdn_mode = 2'b01;
        sample_in = 12'h6AB;
        send_cmd(cmd(3'd0, 1'b1, 1'b1, 2'b10));
        wait_int(CONV_CYC * SLOW_MUL, "R6 slow");
        read_res(r);
        chk("R6 slow result", int'(r), 'h6AB);

        // R4 software power-down still converts
        sample_in = 12'h18E;
        send_cmd(cmd(3'd7, 1'b0, 1'b0, 2'b00));
        chk("R4 sw power_down", int'(power_down), 1);
        chk("R4 sw mode kept", int'(ext_clk_mode), 0);
        wait_int(CONV_CYC * SLOW_MUL, "R4 sw pd conversion");
        read_res(r);
        chk("R4 sw pd result", int'(r), 'h18E);
        shdn_mode = 2'b10;
        sample_in = 12'h222;
        send_cmd(cmd(3'd7, 1'b0, 1'b0, 2'b11));
        chk("R4 power_down cleared", int'(power_down), 0);
        read_res(r);
        chk("R4 wake result", int'(r), 'h222);

        // R8 abort of internal conversion
        shdn_mode = 2'b01;
        send_cmd(cmd(3'd2, 1'b0, 1'b0, 2'b10));
        repeat (12) @(negedge clk);
        chk("R8 converting", int'(sstrb), 0);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 strobe high", int'(sstrb), 1);
        chk("R8 dout low", int'(dout), 0);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        // R8 partial command discarded
        bitclk(1'b1, o); bitclk(1'b0, o); bitclk(1'b1, o); bitclk(1'b1, o);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        sample_in = 12'hC0D;
        send_cmd(cmd(3'd4, 1'b1, 1'b0, 2'b11));
        chk("R8 fresh command chan", int'(chan_sel), 4);
        read_res(r);
        chk("R8 fresh result", int'(r), 'hC0D);

        // R9 hardware power-down
        shdn_mode = 2'b00;
        repeat (6) @(negedge clk);
        chk("R9 power_down", int'(power_down), 1);
        sample_in = 12'hFFF;
        send_cmd(cmd(3'd1, 1'b0, 1'b1, 2'b11));
        chk("R9 fields held", int'(chan_sel), 4);
        chk("R9 strobe", int'(sstrb), 1);
        read_res(r);
        chk("R9 no conversion", int'(r), 0);
        shdn_mode = 2'b10;
        repeat (6) @(negedge clk);
        chk("R9 released", int'(power_down), 0);

        // Random mix of external and fast internal conversions
        for (int k = 0; k < 16; k++) begin
            sel = 3'($urandom_range(0, 7));
            uni = 1'($urandom_range(0, 1));
            sgl = 1'($urandom_range(0, 1));
            use_int = ($urandom_range(0, 3) == 0);
            smp = 12'($urandom_range(0, 4095));
            lead = $urandom_range(0, 3);
            sample_in = smp;
            for (int j = 0; j < lead; j++) bitclk(1'b0, o);
            send_cmd(cmd(sel, uni, sgl, use_int ? 2'b10 : 2'b11));
            chk("R3 random fields", int'({chan_sel, unipolar, single_ended}), int'({sel, uni, sgl}));
            if (use_int) wait_int(CONV_CYC, "R6 random");
            read_res(r);
            chk(use_int ? "R6 random result" : "R5 random result", int'(r), int'(smp));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule